// File: doc/BRIEF.md
# Clock-Driving Serial Byte Transmitter with Optional Holding Buffer

This block sends bytes over a two-wire clocked serial link. It drives the serial clock itself and places one data bit on the data line for each clock period. Each frame is exactly eight data bits, least significant bit first, with no start or stop bits. The data line changes when the clock falls, so it is steady when the clock rises. Both lines rest high when nothing is being sent. The length of each clock phase comes from a divider value, and the serial clock runs only while a byte is being shifted.

A mode input selects how CPU writes reach the shift register. In single-buffer mode a write starts a byte at once, and the interrupt pulses when the eighth bit has gone out. In double-buffer mode a write fills a one-byte holding buffer. The buffer passes its byte to the shift register as soon as the shifter is free, either at once when idle or at the end of the current byte, with no idle gap. Each such hand-over raises the interrupt and sets the buffer-empty flag. A write that cannot be accepted is dropped and sets a sticky overrun flag.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, sclk = 1, sdata = 1, tx_irq = 0, buf_empty = 1 and overrun = 0.
- R2: A frame is 8 bits, least significant bit first, one sclk rising edge per bit. sdata changes only in the cycle sclk falls and holds steady while sclk is high.
- R3: Each low phase and each high phase of sclk lasts div_n+1 system clocks, so one bit takes 2×(div_n+1) clocks.
- R4: With dbl_buf_en = 0, a write accepted while idle drives sclk low in the next cycle. tx_irq is high for one cycle starting 16×(div_n+1) clocks later, when sclk returns high after the eighth bit.
- R5: With dbl_buf_en = 1, a write into the empty holding buffer while idle clears buf_empty after that edge. On the next edge the byte moves to the shifter: sclk goes low, buf_empty returns to 1 and tx_irq pulses.
- R6: With dbl_buf_en = 1, a byte that is waiting when a frame ends is loaded in the same cycle. sclk falls exactly div_n+1 clocks after the last rising edge, with no gap, and tx_irq pulses for that transfer.
- R7: When a frame ends with nothing waiting in double-buffer mode, no interrupt is raised, and sclk and sdata stay high.
- R8: A write while the holding buffer is full (double mode), or while the shifter is busy (single mode), is ignored: the byte is never sent, and overrun becomes 1 and stays 1 until reset.
- R9: tx_irq is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per byte |
| wr_data | input | 8 | Byte written by the CPU |
| dbl_buf_en | input | 1 | 1 = holding buffer in use, 0 = write loads the shifter directly |
| div_n | input | DIV_W | Clock divider value N; each sclk phase lasts N+1 clocks |
| sclk | output | 1 | Serial clock, rests high |
| sdata | output | 1 | Serial data, LSB first, rests high |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |
| buf_empty | output | 1 | Holding buffer has no byte waiting |
| overrun | output | 1 | Sticky flag for a dropped write |

## Verification
The bench targets the hand-over between back-to-back bytes. A design that idles there would stretch one fall-to-fall interval beyond 2×(N+1). A design that used the wrong interrupt rule would give an extra or missing pulse, for example by pulsing at the end of the frame in double-buffer mode. It writes into a full holding buffer and into a busy shifter: a design that accepted such a write would send a third byte or corrupt the second. It also times the single-mode interrupt to the exact cycle and watches buf_empty on the single cycle it is low, which catches an off-by-one in the divider or a late transfer.

// File: rtl/sst_pkg.sv
// Shared constants and types for the serial transmitter.
// Assumes fixed 8-bit frames; all other sizes derive from here.
package sst_pkg;
    localparam int FRAME_BITS = 8;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);
    typedef logic [FRAME_BITS-1:0] frame_t;
endpackage

// File: rtl/sst_clkdiv.sv
// Half-period tick generator for the serial clock.
// Emits one tick every div_n+1 cycles while run is high.
// restart realigns the count to zero in the cycle a byte is loaded.
module sst_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_n);

    // count system clocks within the current sclk phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DIV_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R3
endmodule

// File: rtl/sst_holdbuf.sv
// One-byte holding buffer with empty and overrun tracking.
// Decides when a waiting byte moves to the shifter (take).
// Assumes sh_done is a one-cycle end-of-frame strobe from the shifter.
module sst_holdbuf
    import sst_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  frame_t wr_data,
    input  logic   dbl_buf_en,
    input  logic   sh_busy,
    input  logic   sh_done,
    output logic   take,
    output frame_t hold_data,
    output logic   hold_full,
    output logic   overrun
);
    logic reject;

    assign take   = dbl_buf_en && hold_full && (!sh_busy || sh_done);
    assign reject = wr_en && (dbl_buf_en ? hold_full : sh_busy);

    // hold a written byte until the shifter takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (wr_en && dbl_buf_en && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end
    end

    // latch any dropped write until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (reject) begin
            overrun <= 1'b1;
        end
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_full && !take |=> hold_full); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8
endmodule

// File: rtl/sst_shifter.sv
// Shift register and serial line driver.
// On load it drops sclk and presents bit 0. On each tick it toggles
// sclk, advancing data at falling edges. After the eighth high phase
// it raises done and returns to idle unless a new load arrives.
module sst_shifter
    import sst_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  frame_t load_data,
    input  logic   tick,
    output logic   busy,
    output logic   sclk,
    output logic   sdata,
    output logic   done
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_BITS - 1);

    frame_t               shreg;
    logic [BIT_IDX_W-1:0] bit_idx;

    assign done = busy && tick && sclk && (bit_idx == LAST_BIT);

    // drive the serial clock and data, one bit per two ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b1;
            sdata   <= 1'b1;
            shreg   <= '0;
            bit_idx <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            sclk    <= 1'b0;
            sdata   <= load_data[0];
            shreg   <= load_data;
            bit_idx <= '0;
        end else if (done) begin
            busy  <= 1'b0;
            sclk  <= 1'b1;
            sdata <= 1'b1;
        end else if (busy && tick) begin
            if (!sclk) begin
                sclk <= 1'b1;
            end else begin
                sclk    <= 1'b0;
                sdata   <= shreg[1];
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk && sdata)); // R7
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sclk |-> $stable(sdata)); // R2
endmodule

// File: rtl/sync_ser_tx.sv
// Top of the clock-driving serial transmitter.
// Chooses between direct loading (single mode) and loading from the
// holding buffer (double mode), and forms the transmit interrupt.
// Assumes div_n and dbl_buf_en are changed only while idle.
module sync_ser_tx
    import sst_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             dbl_buf_en,
    input  logic [DIV_W-1:0] div_n,
    output logic             sclk,
    output logic             sdata,
    output logic             tx_irq,
    output logic             buf_empty,
    output logic             overrun
);
    logic   sh_busy, sh_done, tick, take, hold_full, load;
    frame_t hold_data, load_data;

    assign load      = take || (wr_en && !dbl_buf_en && !sh_busy);
    assign load_data = take ? hold_data : frame_t'(wr_data);
    assign buf_empty = !hold_full;

    sst_holdbuf u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (frame_t'(wr_data)),
        .dbl_buf_en (dbl_buf_en),
        .sh_busy    (sh_busy),
        .sh_done    (sh_done),
        .take       (take),
        .hold_data  (hold_data),
        .hold_full  (hold_full),
        .overrun    (overrun)
    );

    sst_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (sh_busy),
        .restart (load),
        .div_n   (div_n),
        .tick    (tick)
    );

    sst_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .tick      (tick),
        .busy      (sh_busy),
        .sclk      (sclk),
        .sdata     (sdata),
        .done      (sh_done)
    );

    // pulse on transfer (double mode) or end of frame (single mode)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq <= 1'b0;
        end else begin
            tx_irq <= dbl_buf_en ? take : sh_done;
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R9
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (buf_empty && !sclk)); // R5
endmodule

// File: tb/sync_ser_tx_tb.sv
// Self-checking bench: table-driven frames, then directed corner cases.
module sync_ser_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       dbl = 1'b0;
    logic [7:0] div = 8'd0;
    logic       sclk, sdata, tx_irq, buf_empty, overrun;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    sync_ser_tx #(.DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dbl_buf_en(dbl), .div_n(div), .sclk(sclk), .sdata(sdata),
        .tx_irq(tx_irq), .buf_empty(buf_empty), .overrun(overrun)
    );

    // line monitor: decodes frames, counts interrupts, checks phase lengths
    int         epoch = 0, seen = 0, exp_half = 1;
    int         cyc = 0, last_fall = -1, nbits = 0;
    int         irq_n = 0, rx_n = 0;
    bit         lo_bad = 0, ff_bad = 0, prev_sclk = 1;
    logic [7:0] shv = 8'h00;
    logic [7:0] rx_buf [64];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (epoch != seen) begin
            seen = epoch; last_fall = -1; nbits = 0; lo_bad = 0; ff_bad = 0;
        end
        if (tx_irq) irq_n = irq_n + 1;
        if (prev_sclk && !sclk) begin
            if (last_fall >= 0 && (cyc - last_fall) != 2 * exp_half) ff_bad = 1;
            last_fall = cyc;
        end
        if (!prev_sclk && sclk) begin
            if ((cyc - last_fall) != exp_half) lo_bad = 1;
            shv = {sdata, shv[7:1]};
            nbits = nbits + 1;
            if (nbits == 8) begin
                rx_buf[rx_n % 64] = shv;
                rx_n = rx_n + 1;
                nbits = 0;
            end
        end
        prev_sclk = sclk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        epoch++;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk) wr_en = 1'b1; wr_data = b;
        @(negedge clk) wr_en = 1'b0;
    endtask

    // {dbl, div[3:0], data}
    localparam logic [12:0] VECS [6] = '{13'h00A5, 13'h113C, 13'h0281,
                                         13'h10FF, 13'h0500, 13'h136E};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int r0, i0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(sclk && sdata, "R1 lines idle", {sclk, sdata}, 3);
        chk(!tx_irq && buf_empty && !overrun, "R1 flags", {tx_irq, buf_empty, overrun}, 2);

        // table of frames: R2 content, R3 phase lengths, R4/R5 one irq, R7 idle after
        for (int i = 0; i < 6; i++) begin
            dbl = VECS[i][12];
            div = {4'd0, VECS[i][11:8]};
            exp_half = int'(VECS[i][11:8]) + 1;
            epoch++;
            @(negedge clk);
            r0 = rx_n; i0 = irq_n;
            wr(VECS[i][7:0]);
            repeat (20 * exp_half + 6) @(negedge clk);
            chk(rx_n == r0 + 1, "R2 frame count", rx_n - r0, 1);
            chk(rx_buf[r0 % 64] == VECS[i][7:0], "R2 LSB-first data",
                rx_buf[r0 % 64], VECS[i][7:0]);
            chk(!lo_bad && !ff_bad, "R3 phase length", {lo_bad, ff_bad}, 0);
            chk(irq_n == i0 + 1, "R4/R5 irq count", irq_n - i0, 1);
            chk(sclk && sdata && buf_empty, "R7 idle after frame", {sclk, sdata, buf_empty}, 7);
        end

        // R4 exact single-mode timing
        do_reset();
        dbl = 1'b0; div = 8'd3; exp_half = 4;
        wr(8'h5A);
        chk(!sclk && !tx_irq, "R4 start next cycle", {sclk, tx_irq}, 0);
        repeat (63) @(negedge clk);
        chk(!tx_irq, "R4 irq not early", tx_irq, 0);
        @(negedge clk);
        chk(tx_irq && sclk, "R4 irq at end", {tx_irq, sclk}, 3);
        @(negedge clk);
        chk(!tx_irq, "R9 single pulse", tx_irq, 0);

        // R5 double-mode transfer from idle
        do_reset();
        dbl = 1'b1; div = 8'd0; exp_half = 1;
        wr(8'hC3);
        chk(!buf_empty && !tx_irq && sclk, "R5 held one cycle",
            {buf_empty, tx_irq, sclk}, 1);
        @(negedge clk);
        chk(buf_empty && tx_irq && !sclk, "R5 transfer", {buf_empty, tx_irq, sclk}, 6);
        repeat (30) @(negedge clk);

        // R6 gapless back-to-back, R8 overrun in double mode
        do_reset();
        dbl = 1'b1; div = 8'd1; exp_half = 2;
        epoch++;
        @(negedge clk);
        r0 = rx_n; i0 = irq_n;
        wr(8'h81);
        @(negedge clk);
        wr(8'h7E);
        wr(8'hFF);  // holding buffer full: must be dropped
        chk(overrun == 1'b1, "R8 overrun set (double)", overrun, 1);
        repeat (80) @(negedge clk);
        chk(rx_n == r0 + 2, "R8 dropped byte not sent", rx_n - r0, 2);
        chk(rx_buf[r0 % 64] == 8'h81 && rx_buf[(r0 + 1) % 64] == 8'h7E,
            "R6 byte order", rx_buf[(r0 + 1) % 64], 8'h7E);
        chk(!ff_bad && !lo_bad, "R6 no gap between frames", {ff_bad, lo_bad}, 0);
        chk(irq_n == i0 + 2, "R6 irq per transfer", irq_n - i0, 2);
        chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);

        // R8 single mode: write while busy dropped
        do_reset();
        dbl = 1'b0; div = 8'd2; exp_half = 3;
        epoch++;
        @(negedge clk);
        r0 = rx_n;
        wr(8'h96);
        repeat (5) @(negedge clk);
        wr(8'h11);
        repeat (70) @(negedge clk);
        chk(rx_n == r0 + 1 && rx_buf[r0 % 64] == 8'h96, "R8 busy write dropped",
            rx_n - r0, 1);
        chk(overrun == 1'b1, "R8 overrun set (single)", overrun, 1);
        do_reset();
        @(negedge clk);
        chk(!overrun, "R1 reset clears overrun", overrun, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule